// File: doc/BRIEF.md
# Two-Layer Global Alpha Window Blender

This block merges two RGB888 pixel streams, a background plane and a foreground overlay plane, into one display pixel. Both planes arrive together with the screen coordinate of the pixel. A single register-held alpha weights the foreground against the background, uniformly, inside a rectangular foreground window. Outside that window, or whenever the overlay is not active, the background passes through unchanged.

Software-side settings reach the block through a small write port. One word holds the layer enables and mode bits, one holds the alpha in its top byte, and two hold the window and background origins. A separate alpha request port clamps out-of-range values. An overlay-off strobe drops the foreground layer and hands the graphic window back to the background.

A two-state machine records which layer the graphic window belongs to. In WIN_ON_BG the window stays on the background. In WIN_ON_FG it stays on the foreground. Transition T_SELECT_FG runs from WIN_ON_BG to WIN_ON_FG when the common word is written with its select bit set. Transition T_RETURN_BG runs from WIN_ON_FG to WIN_ON_BG when the common word is written with that bit clear, or when the overlay-off strobe fires. The arithmetic is a two-stage pipeline: weighted sum first, exact divide by 255 second.

Top module: `win_blender`

## Requirements
- R1: After reset, out_valid is 0, both layers are disabled, alpha is 0 and the window belongs to the background, so any valid pixel produces 24'h000000.
- R2: A pulse on alpha_we with alpha_req at most 255 sets the alpha to alpha_req for pixels presented from the next cycle on; the other bits of the window-control word are kept.
- R3: An alpha_req above 255 is clamped to 255, so a window pixel then equals the foreground pixel exactly.
- R4: Inside the window, with the foreground enabled, the window on the foreground and global alpha mode on, each channel (red [23:16], green [15:8], blue [7:0]) is floor((a*fg + (255-a)*bg)/255).
- R5: A pulse on ovl_off clears the foreground enable and returns the window to the background, so window pixels show the background again.
- R6: Outside the window, or with the foreground disabled, or with the window on the background, the output equals the background contribution.
- R7: The background contribution is black when the background is disabled, or when x is below the background x origin, or when y is below the background y origin.
- R8: out_valid, out_x and out_y equal in_valid, in_x and in_y from exactly two cycles earlier, and out_pix belongs to that same pixel.
- R9: With global alpha mode off, a window pixel equals the foreground pixel, whatever the alpha.
- R10: Writes use cfg_sel encodings. Code 0 is the common word: bit 9 background enable, bit 4 foreground enable, bit 5 window-on-foreground select, bit 6 global alpha mode. Code 1 is the window-control word, with alpha in [31:24]. Code 2 is the foreground origin and code 3 the background origin; in both, x sits at [16+XW-1:16] and y at [YW-1:0]. The window covers fg_x <= x < fg_x+FG_W and fg_y <= y < fg_y+FG_H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings word write strobe |
| cfg_sel | input | 2 | Which settings word is written |
| cfg_wdata | input | 32 | Settings word data |
| alpha_we | input | 1 | Alpha request strobe |
| alpha_req | input | 10 | Requested alpha, clamped to 255 |
| ovl_off | input | 1 | Overlay-off strobe |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | XW | Screen x of input pixel |
| in_y | input | YW | Screen y of input pixel |
| bg_pix | input | 24 | Background RGB888 pixel |
| fg_pix | input | 24 | Foreground RGB888 pixel |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | XW | Screen x of output pixel |
| out_y | output | YW | Screen y of output pixel |
| out_pix | output | 24 | Blended RGB888 pixel |

## Verification
Directed pixels placed one step either side of every window edge separate a correct inclusive/exclusive bound from an off-by-one compare. Alphas of 0, 128 and a clamped request above 255 separate the weight path from plain selection and from an unclamped truncation. Sequences of overlay-off, select and mode writes show whether each gate of the blend is honoured on its own. A long seeded random run then mixes valid gaps, coordinates around both origins and interleaved settings writes. That run exposes any pixel that uses settings from the wrong cycle, or any sideband that leaves its two-stage alignment.

// File: rtl/blend_pkg.sv
package blend_pkg;
    localparam int unsigned CB_FG_EN  = 4;
    localparam int unsigned CB_WINSEL = 5;
    localparam int unsigned CB_GLB    = 6;
    localparam int unsigned CB_BG_EN  = 9;
    localparam int unsigned ALPHA_LSB = 24;
    localparam int unsigned POS_X_LSB = 16;
    localparam int unsigned CH_W      = 8;
    localparam int unsigned N_CH      = 3;

    typedef enum logic [1:0] {
        SEL_COMMON = 2'd0,
        SEL_GWCTRL = 2'd1,
        SEL_FGPOS  = 2'd2,
        SEL_BGPOS  = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        WIN_ON_BG = 1'b0,
        WIN_ON_FG = 1'b1
    } win_state_e;
endpackage

// File: rtl/blend_cfg.sv
module blend_cfg
    import blend_pkg::*;
#(
    parameter int unsigned XW = 12,
    parameter int unsigned YW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          alpha_we,
    input  logic [9:0]    alpha_req,
    input  logic          ovl_off,
    output logic          bg_en,
    output logic          fg_en,
    output logic          glb_mode,
    output logic          win_fg,
    output logic [7:0]    alpha,
    output logic [XW-1:0] fg_x,
    output logic [YW-1:0] fg_y,
    output logic [XW-1:0] bg_x,
    output logic [YW-1:0] bg_y
);
    win_state_e  state_q, state_d;
    logic [31:0] gw_q;
    logic        wr_common, wr_gw;

    assign wr_common = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_COMMON);
    assign wr_gw     = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_GWCTRL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_ON_BG: if (!ovl_off && wr_common && cfg_wdata[CB_WINSEL])
                           state_d = WIN_ON_FG;
            WIN_ON_FG: if (ovl_off || (wr_common && !cfg_wdata[CB_WINSEL]))
                           state_d = WIN_ON_BG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_ON_BG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_en <= 1'b0; fg_en <= 1'b0; glb_mode <= 1'b0;
            gw_q <= '0;
            fg_x <= '0; fg_y <= '0; bg_x <= '0; bg_y <= '0;
        end else begin
            if (wr_common) begin
                bg_en    <= cfg_wdata[CB_BG_EN];
                fg_en    <= cfg_wdata[CB_FG_EN];
                glb_mode <= cfg_wdata[CB_GLB];
            end
            if (ovl_off) fg_en <= 1'b0;
            if (wr_gw) gw_q <= cfg_wdata;
            if (alpha_we)
                gw_q[31:ALPHA_LSB] <= (alpha_req > 10'd255) ? 8'hFF : alpha_req[7:0];
            if (cfg_we && cfg_sel_e'(cfg_sel) == SEL_FGPOS) begin
                fg_x <= cfg_wdata[POS_X_LSB +: XW];
                fg_y <= cfg_wdata[YW-1:0];
            end
            if (cfg_we && cfg_sel_e'(cfg_sel) == SEL_BGPOS) begin
                bg_x <= cfg_wdata[POS_X_LSB +: XW];
                bg_y <= cfg_wdata[YW-1:0];
            end
        end
    end

    always_comb begin
        win_fg = (state_q == WIN_ON_FG);
        alpha  = gw_q[31:ALPHA_LSB];
    end

    // R3: oversize alpha requests land as 255
    p_alpha_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha_we && alpha_req > 10'd255) |=> (alpha == 8'hFF));
    // R2: alpha update keeps the low 24 bits of the control word
    p_alpha_keeps_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha_we && !wr_gw) |=> (gw_q[23:0] == $past(gw_q[23:0])));
    // R5: overlay-off drops foreground and returns window to background
    p_ovl_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_off |=> (!fg_en && state_q == WIN_ON_BG));
endmodule

// File: rtl/blend_window.sv
module blend_window #(
    parameter int unsigned XW   = 12,
    parameter int unsigned YW   = 12,
    parameter int unsigned FG_W = 64,
    parameter int unsigned FG_H = 48
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] fg_x,
    input  logic [YW-1:0] fg_y,
    input  logic [XW-1:0] bg_x,
    input  logic [YW-1:0] bg_y,
    output logic          in_fg_win,
    output logic          in_bg_area
);
    localparam logic [XW:0] W_EXT = (XW+1)'(FG_W);
    localparam logic [YW:0] H_EXT = (YW+1)'(FG_H);

    logic [XW:0] x_end;
    logic [YW:0] y_end;

    always_comb begin
        x_end      = {1'b0, fg_x} + W_EXT;
        y_end      = {1'b0, fg_y} + H_EXT;
        in_fg_win  = (x >= fg_x) && ({1'b0, x} < x_end) &&
                     (y >= fg_y) && ({1'b0, y} < y_end);
        in_bg_area = (x >= bg_x) && (y >= bg_y);
    end
endmodule

// File: rtl/blend_chan.sv
module blend_chan
    import blend_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] bg_c,
    input  logic [CH_W-1:0] fg_c,
    input  logic [CH_W-1:0] alpha,
    input  logic            blend,
    output logic [CH_W-1:0] out_c
);
    localparam int unsigned SW = 2*CH_W;

    logic [SW-1:0] sum_d, sum_q;
    logic [SW:0]   div_t;

    always_comb begin
        if (blend)
            sum_d = SW'(alpha) * SW'(fg_c) + SW'(8'd255 - alpha) * SW'(bg_c);
        else
            sum_d = SW'(bg_c) * SW'(8'd255);
        div_t = {1'b0, sum_q} + (SW+1)'(1) + (SW+1)'(sum_q >> CH_W);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            out_c <= '0;
        end else begin
            sum_q <= sum_d;
            out_c <= div_t[CH_W +: CH_W];
        end
    end
endmodule

// File: rtl/win_blender.sv
module win_blender
    import blend_pkg::*;
#(
    parameter int unsigned XW   = 12,
    parameter int unsigned YW   = 12,
    parameter int unsigned FG_W = 64,
    parameter int unsigned FG_H = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          alpha_we,
    input  logic [9:0]    alpha_req,
    input  logic          ovl_off,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic [23:0]   bg_pix,
    input  logic [23:0]   fg_pix,
    output logic          out_valid,
    output logic [XW-1:0] out_x,
    output logic [YW-1:0] out_y,
    output logic [23:0]   out_pix
);
    localparam int unsigned PW = N_CH * CH_W;

    logic          bg_en, fg_en, glb_mode, win_fg;
    logic [7:0]    alpha, alpha_eff;
    logic [XW-1:0] fg_x, bg_x;
    logic [YW-1:0] fg_y, bg_y;
    logic          in_fg_win, in_bg_area, blend;
    logic [PW-1:0] bg_eff;
    logic          v1_q;
    logic [XW-1:0] x1_q;
    logic [YW-1:0] y1_q;
    logic [1:0]    warm_q;

    blend_cfg #(.XW(XW), .YW(YW)) u_cfg (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .alpha_we, .alpha_req,
        .ovl_off, .bg_en, .fg_en, .glb_mode, .win_fg, .alpha,
        .fg_x, .fg_y, .bg_x, .bg_y
    );

    blend_window #(.XW(XW), .YW(YW), .FG_W(FG_W), .FG_H(FG_H)) u_win (
        .x(in_x), .y(in_y), .fg_x, .fg_y, .bg_x, .bg_y,
        .in_fg_win, .in_bg_area
    );

    always_comb begin
        blend     = fg_en && win_fg && in_fg_win;
        alpha_eff = glb_mode ? alpha : 8'hFF;
        bg_eff    = (bg_en && in_bg_area) ? bg_pix : '0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        blend_chan u_ch (
            .clk, .rst_n,
            .bg_c  (bg_eff[c*CH_W +: CH_W]),
            .fg_c  (fg_pix[c*CH_W +: CH_W]),
            .alpha (alpha_eff),
            .blend,
            .out_c (out_pix[c*CH_W +: CH_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0; x1_q <= '0; y1_q <= '0;
            out_valid <= 1'b0; out_x <= '0; out_y <= '0;
            warm_q <= '0;
        end else begin
            v1_q <= in_valid; x1_q <= in_x; y1_q <= in_y;
            out_valid <= v1_q; out_x <= x1_q; out_y <= y1_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    // R8: valid and coordinates emerge two cycles after entry
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2) &&
                              out_x == $past(in_x, 2) && out_y == $past(in_y, 2)));
endmodule

// File: tb/sim_win_blender.sv
`timescale 1ns/1ps
module sim_win_blender;
    localparam int XW = 12, YW = 12, FW = 16, FH = 8;
    localparam real TCK = 8.0;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, alpha_we = 0, ovl_off = 0, in_valid = 0;
    logic [1:0] cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic [9:0] alpha_req = 0;
    logic [XW-1:0] in_x = 0;
    logic [YW-1:0] in_y = 0;
    logic [23:0] bg_pix = 0, fg_pix = 0;
    logic out_valid;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [23:0] out_pix;

    always #(TCK/2) clk = ~clk;

    win_blender #(.XW(XW), .YW(YW), .FG_W(FW), .FG_H(FH)) u0 (.*);

    typedef struct { bit v; int x; int y; logic [23:0] p; string tag; } exp_t;
    exp_t pipe [2];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bit m_bg, m_fg, m_sel, m_glb;
    int m_a, fgx, fgy, bgx, bgy;

    function automatic logic [23:0] ref_pix(int x, int y, logic [23:0] b, logic [23:0] f);
        logic [23:0] bc, r;
        int a;
        bc = (m_bg && x >= bgx && y >= bgy) ? b : 24'h0;
        if (m_fg && m_sel && x >= fgx && x < fgx+FW && y >= fgy && y < fgy+FH) begin
            a = m_glb ? m_a : 255;
            for (int c = 0; c < 3; c++)
                r[c*8 +: 8] = 8'((a*int'(f[c*8 +: 8]) + (255-a)*int'(bc[c*8 +: 8])) / 255);
            return r;
        end
        return bc;
    endfunction

    function automatic string auto_tag(int x, int y);
        bit inw = x >= fgx && x < fgx+FW && y >= fgy && y < fgy+FH;
        if (m_fg && m_sel && inw) return m_glb ? "R4" : "R9";
        if (!m_bg || x < bgx || y < bgy) return "R7";
        return "R6";
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(exp_t e);
        @(negedge clk);
        chk("R8 valid", int'(out_valid), int'(pipe[1].v));
        if (pipe[1].v) begin
            chk("R8 x", int'(out_x), pipe[1].x);
            chk("R8 y", int'(out_y), pipe[1].y);
            chk(pipe[1].tag, int'(out_pix), int'(pipe[1].p));
        end
        pipe[1] = pipe[0];
        pipe[0] = e;
        cfg_we = 0; alpha_we = 0; ovl_off = 0; in_valid = 0;
    endtask

    task automatic idle();
        exp_t e;
        e.v = 0; e.x = 0; e.y = 0; e.p = 0; e.tag = "R8";
        tick(e);
    endtask

    task automatic pix(int x, int y, logic [23:0] b, logic [23:0] f, string tag = "");
        exp_t e;
        e.v = 1; e.x = x; e.y = y; e.p = ref_pix(x, y, b, f);
        e.tag = (tag == "") ? auto_tag(x, y) : tag;
        tick(e);
        in_valid = 1; in_x = XW'(x); in_y = YW'(y); bg_pix = b; fg_pix = f;
    endtask

    task automatic wcfg(int sel, logic [31:0] d);
        idle();
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = d;
        case (sel)
            0: begin m_bg = d[9]; m_fg = d[4]; m_sel = d[5]; m_glb = d[6]; end
            1: m_a = int'(d[31:24]);
            2: begin fgx = int'(d[27:16]); fgy = int'(d[11:0]); end
            default: begin bgx = int'(d[27:16]); bgy = int'(d[11:0]); end
        endcase
    endtask

    task automatic walpha(int r);
        idle();
        alpha_we = 1; alpha_req = 10'(r);
        m_a = (r > 255) ? 255 : r;
    endtask

    task automatic woff();
        idle();
        ovl_off = 1; m_fg = 0; m_sel = 0;
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        pipe[0].v = 0; pipe[1].v = 0; pipe[0].tag = "R8"; pipe[1].tag = "R8";
        m_bg = 0; m_fg = 0; m_sel = 0; m_glb = 0; m_a = 0;
        fgx = 0; fgy = 0; bgx = 0; bgy = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 pix", int'(out_pix), 0);
        // R1: default state yields black
        pix(3, 3, 24'h123456, 24'hABCDEF, "R1");
        pix(30, 12, 24'hFFFFFF, 24'h00FF00, "R1");
        // R6: background only
        wcfg(0, 32'h200);
        pix(1, 1, 24'h0F1E2D, 24'hFFFFFF, "R6");
        // R7: background origin masks earlier pixels
        wcfg(3, (32'd5 << 16) | 32'd3);
        pix(4, 9, 24'h777777, 24'h0, "R7");
        pix(9, 2, 24'h777777, 24'h0, "R7");
        pix(5, 3, 24'h777777, 24'h0, "R7");
        // R10 / R4: window, blend with alpha 128
        wcfg(2, (32'd20 << 16) | 32'd10);
        wcfg(0, 32'h270);
        walpha(128);
        pix(25, 12, 24'h102030, 24'hF0E0D0, "R4");
        pix(19, 10, 24'h102030, 24'hF0E0D0, "R10");
        pix(20, 10, 24'h102030, 24'hF0E0D0, "R10");
        pix(20+FW-1, 10+FH-1, 24'h102030, 24'hF0E0D0, "R10");
        pix(20+FW, 12, 24'h102030, 24'hF0E0D0, "R10");
        pix(22, 10+FH, 24'h102030, 24'hF0E0D0, "R10");
        pix(22, 9, 24'h102030, 24'hF0E0D0, "R10");
        // R3: clamp
        walpha(700);
        pix(24, 13, 24'h334455, 24'hC1C2C3, "R3");
        // R2: alpha 0 and a mid value
        walpha(0);
        pix(24, 13, 24'h334455, 24'hC1C2C3, "R2");
        walpha(77);
        pix(21, 11, 24'h00FF80, 24'hFF0080, "R2");
        // R9: global mode off
        wcfg(0, 32'h230);
        pix(26, 14, 24'h010203, 24'h9A8B7C, "R9");
        // R6: window on background
        wcfg(0, 32'h250);
        pix(26, 14, 24'h010203, 24'h9A8B7C, "R6");
        // R5: overlay off
        wcfg(0, 32'h270);
        woff();
        pix(26, 14, 24'h445566, 24'hEEEEEE, "R5");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 31));
            if (r == 0) wcfg(0, {22'd0, 1'($urandom), 2'd0, 1'($urandom),
                                 1'($urandom), 1'($urandom), 1'($urandom), 4'd0});
            else if (r == 1) walpha(int'($urandom_range(0, 400)));
            else if (r == 2) wcfg(2, (32'($urandom_range(0, 30)) << 16) | 32'($urandom_range(0, 15)));
            else if (r == 3) wcfg(3, (32'($urandom_range(0, 8)) << 16) | 32'($urandom_range(0, 6)));
            else if (r == 4) woff();
            else if (r < 10) idle();
            else pix(int'($urandom_range(0, 47)), int'($urandom_range(0, 23)),
                     24'($urandom), 24'($urandom));
        end
        repeat (3) idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule